// File: doc/BRIEF.md
# Serial ADC Frame Sequencer

This block is the master side of a link to a single-channel, 10-bit, three-wire serial converter. It divides the system clock down to a serial clock and drives an active-low select line. It also shifts in the converter's data line and hands each recovered straight-binary code to the rest of the chip with a one-cycle valid strobe. One frame can be launched with a start pulse, or frames can follow back to back while the run enable is held high.

Two frame lengths are offered. The fixed mode always spaces select falls 20 serial-clock periods apart. The compact mode spaces them by 12.5 periods of hold, then the longer of the acquisition time and the 2.5-period read-out tail, then padding. The padding brings the spacing up to the first point where a serial-clock falling edge is due. All timing is counted in half serial-clock periods. Each half period lasts a programmable number of system clocks.

Top module: `adc_frame_seq`

## Requirements
- R1: While select is low, sclk is low for exactly H system clocks and high for exactly H system clocks, where H is the half-period input `half_div` (H >= 1). While select is high, sclk is held high.
- R2: Select falls only while sclk is high. The first sclk falling edge of a frame follows the select fall by exactly H system clocks.
- R3: With `short_mode` = 0 and run held, successive select falls are 40*H system clocks apart (20 serial periods), whatever `acq_clks` holds.
- R4: With `short_mode` = 1 and run held, select falls are N*H system clocks apart. N is the smallest even number of half periods with N >= 32 and (N - 25)*H >= `acq_clks`.
- R5: Frame bit k is the value of `sdata_in` at the k-th sclk rising edge after select falls. Bits 1 to 3 are leading zeros, and bits 4 to 13 are the code, MSB first. `result` is that 10-bit code in straight binary (000h to 3FFh).
- R6: `result_valid` is high for exactly one system clock after each capture. `result` changes only in that cycle and otherwise holds its last value.
- R7: Each frame has exactly 13 sclk rising edges while select is low. Select rises together with the 13th rising edge, 26*H system clocks after it fell.
- R8: Divider, acquisition time and mode are taken when a frame begins. Changes during a frame do not alter that frame's sclk period.
- R9: With `run_en` low, a one-cycle `start` launches exactly one frame. Select then stays high until the next request.
- R10: During and right after reset, `cs_n` = 1, `sclk` = 1, `result_valid` = 0 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | System clocks per sclk half period (0 treated as 1) |
| acq_clks | input | ACQ_W | Minimum acquisition time in system clocks (compact mode) |
| short_mode | input | 1 | 0: fixed 20-period frame, 1: compact frame |
| run_en | input | 1 | Keep launching frames back to back |
| start | input | 1 | Launch a single frame when idle |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock to the converter |
| result | output | CODE_W | Last recovered conversion code |
| result_valid | output | 1 | One-cycle strobe on a new code |

## Verification
The assertions assume that `half_div` is at least 1. They also assume that the converter changes `sdata_in` only after an sclk falling edge, so the line is settled by the next rise. The stimulus holds reset for several cycles so that every register has a defined value before the checks start. The bench's converter model updates its data line only on sclk falling edges, and every divider it programs is 1 or more. Configuration changes happen either between frames or deliberately in the middle of a single frame, and there they must not disturb the frame already running.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;
  // frame length selection
  typedef enum logic {
    FRAME_FIXED = 1'b0,
    FRAME_SHORT = 1'b1
  } frame_mode_e;

  // default frame layout, in serial bits / half periods
  localparam int LEAD_ZEROS_DEF  = 3;
  localparam int FIXED_SCLKS_DEF = 20;
  localparam int TAIL_HALVES_DEF = 5;
endpackage

// File: rtl/adcseq_halftick.sv
`timescale 1ns/1ps
module adcseq_halftick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             active,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = active && (cnt == half_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adcseq_framectl.sv
`timescale 1ns/1ps
module adcseq_framectl
  import adcseq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int ACQ_W       = 12,
  parameter int CODE_W      = 10,
  parameter int LEAD_BITS   = LEAD_ZEROS_DEF,
  parameter int FIXED_SCLKS = FIXED_SCLKS_DEF,
  parameter int TAIL_HALVES = TAIL_HALVES_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_div,
  input  logic [ACQ_W-1:0] acq_clks,
  input  logic             short_mode,
  input  logic             run_en,
  input  logic             start,
  input  logic             tick,
  output logic             go,
  output logic             active,
  output logic [DIV_W-1:0] div_l,
  output logic             cs_n,
  output logic             sclk,
  output logic             cap_en,
  output logic             cap_last
);
  localparam int LAST_BIT    = LEAD_BITS + CODE_W;
  localparam int FIRST_BIT   = LEAD_BITS + 1;
  localparam int CAP_HALF    = 2 * LAST_BIT;
  localparam int HOLD_HALVES = CAP_HALF - 1;
  localparam int FIX_HALVES  = 2 * FIXED_SCLKS;
  localparam int BASE_SHORT  = HOLD_HALVES + TAIL_HALVES;
  localparam int MIN_SHORT   = (BASE_SHORT % 2 == 0) ? BASE_SHORT + 2 : BASE_SHORT + 1;
  localparam int HCNT_W      = $clog2(FIX_HALVES + BASE_SHORT + (1 << ACQ_W) + 4);

  localparam logic [HCNT_W-1:0] FIX_N   = HCNT_W'(FIX_HALVES);
  localparam logic [HCNT_W-1:0] MIN_N   = HCNT_W'(MIN_SHORT);
  localparam logic [HCNT_W-1:0] HOLD_N  = HCNT_W'(HOLD_HALVES);
  localparam logic [HCNT_W-1:0] CAP_N   = HCNT_W'(CAP_HALF);
  localparam logic [HCNT_W-1:0] FIRST_N = HCNT_W'(2 * FIRST_BIT);

  frame_mode_e       mode_l;
  logic [ACQ_W-1:0]  acq_l;
  logic [ACQ_W-1:0]  acc;
  logic [HCNT_W-1:0] hcnt;
  logic [HCNT_W-1:0] nh;
  logic              acq_ok;
  logic              end_hit;
  logic              want;

  assign want   = run_en || start;
  assign nh     = hcnt + 1'b1;
  assign acq_ok = ({1'b0, acc} + 1'b1) >= {1'b0, acq_l};

  always_comb begin
    end_hit = 1'b0;
    if (active && tick) begin
      if (mode_l == FRAME_FIXED) begin
        end_hit = (nh == FIX_N);
      end else begin
        end_hit = !nh[0] && (nh >= MIN_N) && acq_ok;
      end
    end
  end

  assign go       = want && (!active || end_hit);
  assign cap_en   = active && tick && !nh[0] && (nh >= FIRST_N) && (nh <= CAP_N);
  assign cap_last = active && tick && (nh == CAP_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      hcnt   <= '0;
      acc    <= '0;
      acq_l  <= '0;
      div_l  <= DIV_W'(1);
      mode_l <= FRAME_FIXED;
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
    end else if (go) begin
      active <= 1'b1;
      hcnt   <= '0;
      acc    <= '0;
      acq_l  <= acq_clks;
      div_l  <= (half_div == '0) ? DIV_W'(1) : half_div;
      mode_l <= frame_mode_e'(short_mode);
      cs_n   <= 1'b0;
      sclk   <= 1'b1;
    end else if (end_hit) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
    end else if (active) begin
      if ((hcnt >= HOLD_N) && (acc != '1)) begin
        acc <= acc + 1'b1;
      end
      if (tick) begin
        hcnt <= nh;
        if (nh <= CAP_N) begin
          sclk <= ~nh[0];
        end
        if (nh == CAP_N) begin
          cs_n <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adcseq_capture.sv
`timescale 1ns/1ps
module adcseq_capture #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              cap_last,
  input  logic              sdata,
  output logic [CODE_W-1:0] result,
  output logic              result_valid
);
  logic [CODE_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh           <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (cap_en) begin
        sh <= {sh[CODE_W-3:0], sdata};
        if (cap_last) begin
          result       <= {sh, sdata};
          result_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq
  import adcseq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int ACQ_W       = 12,
  parameter int CODE_W      = 10,
  parameter int LEAD_BITS   = LEAD_ZEROS_DEF,
  parameter int FIXED_SCLKS = FIXED_SCLKS_DEF,
  parameter int TAIL_HALVES = TAIL_HALVES_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [ACQ_W-1:0]  acq_clks,
  input  logic              short_mode,
  input  logic              run_en,
  input  logic              start,
  input  logic              sdata_in,
  output logic              cs_n,
  output logic              sclk,
  output logic [CODE_W-1:0] result,
  output logic              result_valid
);
  logic             go;
  logic             active;
  logic             tick;
  logic             cap_en;
  logic             cap_last;
  logic [DIV_W-1:0] div_l;

  adcseq_halftick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart  (go),
    .active   (active),
    .half_len (div_l),
    .tick     (tick)
  );

  adcseq_framectl #(
    .DIV_W       (DIV_W),
    .ACQ_W       (ACQ_W),
    .CODE_W      (CODE_W),
    .LEAD_BITS   (LEAD_BITS),
    .FIXED_SCLKS (FIXED_SCLKS),
    .TAIL_HALVES (TAIL_HALVES)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .half_div   (half_div),
    .acq_clks   (acq_clks),
    .short_mode (short_mode),
    .run_en     (run_en),
    .start      (start),
    .tick       (tick),
    .go         (go),
    .active     (active),
    .div_l      (div_l),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .cap_en     (cap_en),
    .cap_last   (cap_last)
  );

  adcseq_capture #(.CODE_W(CODE_W)) u_cap (
    .clk          (clk),
    .rst          (rst),
    .cap_en       (cap_en),
    .cap_last     (cap_last),
    .sdata        (sdata_in),
    .result       (result),
    .result_valid (result_valid)
  );
endmodule

// File: rtl/adcseq_chk.sv
`timescale 1ns/1ps
module adcseq_chk #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic [CODE_W-1:0] result,
  input logic              result_valid
);
  // R10: reset forces the idle output state
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (cs_n && sclk && !result_valid && (result == '0)));

  // R1: sclk parked high whenever select is deasserted
  a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  // R2: select falls only while sclk is and was high
  a_r2_cs_fall_sclk_high: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (sclk && $past(sclk)));

  // R7: select rises together with an sclk rising edge
  a_r7_cs_rise_on_sclk_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $rose(sclk));

  // R6: valid lasts a single cycle
  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R6: result is held outside the valid cycle
  a_r6_result_held: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));
endmodule

bind adc_frame_seq adcseq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .sclk         (sclk),
  .result       (result),
  .result_valid (result_valid)
);

// File: tb/test_adc_frame_seq.sv
`timescale 1ns/1ps
module test_adc_frame_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] half_div = 8'd2;
  logic [11:0] acq_clks = '0;
  logic       short_mode = 1'b0;
  logic       run_en = 1'b0;
  logic       start = 1'b0;
  logic       sdata_in = 1'b0;
  logic       cs_n;
  logic       sclk;
  logic [9:0] result;
  logic       result_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int rises = 0;
  int bidx = 0;
  logic [9:0] cur = '0;
  logic [9:0] ev;
  logic [9:0] mq[$];
  logic [9:0] eq[$];

  always #10 clk = ~clk;

  adc_frame_seq i_adc_frame_seq (
    .clk          (clk),
    .rst          (rst),
    .half_div     (half_div),
    .acq_clks     (acq_clks),
    .short_mode   (short_mode),
    .run_en       (run_en),
    .start        (start),
    .sdata_in     (sdata_in),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .result       (result),
    .result_valid (result_valid)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_halves(int h, int acq, bit sm);
    int n;
    if (!sm) return 40;
    n = 32;
    while ((n - 25) * h < acq) n += 2;
    return n;
  endfunction

  task automatic push(logic [9:0] c);
    mq.push_back(c);
    eq.push_back(c);
  endtask

  // converter model: new bit after each sclk fall
  always @(negedge cs_n) begin
    cur = (mq.size() != 0) ? mq.pop_front() : 10'h000;
    bidx = 0;
    sdata_in = 1'b0;
  end

  always @(negedge sclk) begin
    if (cs_n == 1'b0) begin
      bidx++;
      sdata_in = (bidx >= 4 && bidx <= 13) ? cur[13 - bidx] : 1'b0;
    end
  end

  always @(posedge sclk) rises++;

  // scoreboard monitor, R5
  always @(negedge clk) begin
    if (!rst && result_valid) begin
      if (eq.size() == 0) begin
        chk(1'b0, "R5", int'(result), -1);
      end else begin
        ev = eq.pop_front();
        chk(result == ev, "R5", int'(result), int'(ev));
      end
    end
  end

  task automatic run_block(int h, int acq, bit sm, int n, logic [9:0] base);
    time tp;
    int gap;
    int exp_gap;
    @(negedge clk);
    half_div = 8'(h);
    acq_clks = 12'(acq);
    short_mode = sm;
    for (int i = 0; i < n; i++) push(10'(base + i * 10'h0F3));
    exp_gap = exp_halves(h, acq, sm) * h;
    run_en = 1'b1;
    tp = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge cs_n);
      if (i > 0) begin
        gap = int'(($time - tp) / 20);
        chk(gap == exp_gap, sm ? "R4" : "R3", gap, exp_gap);
      end
      tp = $time;
    end
    @(negedge clk);
    run_en = 1'b0;
    @(posedge cs_n);
    repeat (exp_gap + 10) @(negedge clk);
    chk(cs_n == 1'b1, "R9", int'(cs_n), 1);
  endtask

  task automatic one_shot(int h, int acq, bit sm, logic [9:0] code, int newh);
    time t0;
    time t1;
    int base;
    int d;
    bit extra;
    @(negedge clk);
    half_div = 8'(h);
    acq_clks = 12'(acq);
    short_mode = sm;
    push(code);
    start = 1'b1;
    @(negedge cs_n);
    t0 = $time;
    base = rises;
    @(negedge clk);
    start = 1'b0;
    half_div = 8'(newh);   // R8: must not reach the running frame
    acq_clks = 12'd4000;
    short_mode = ~sm;
    @(negedge sclk);
    d = int'(($time - t0) / 20);
    chk(d == h, "R2", d, h);
    t1 = $time;
    @(posedge sclk);
    d = int'(($time - t1) / 20);
    chk(d == h, "R1 R8", d, h);
    @(posedge cs_n);
    d = int'(($time - t0) / 20);
    chk(d == 26 * h, "R7", d, 26 * h);
    @(negedge clk);
    chk((rises - base) == 13, "R7", rises - base, 13);
    chk(sclk == 1'b1, "R1", int'(sclk), 1);
    repeat (3) @(negedge clk);
    chk(result_valid == 1'b0, "R6", int'(result_valid), 0);
    chk(result == code, "R6", int'(result), int'(code));
    extra = 0;
    repeat (200) begin
      @(negedge clk);
      if (cs_n == 1'b0) extra = 1;
    end
    chk(!extra, "R9", int'(extra), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(cs_n == 1'b1, "R10", int'(cs_n), 1);
    chk(sclk == 1'b1, "R10", int'(sclk), 1);
    chk(result_valid == 1'b0, "R10", int'(result_valid), 0);
    chk(result == 10'h000, "R10", int'(result), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    one_shot(2, 0, 1'b0, 10'h2C5, 5);
    one_shot(1, 0, 1'b1, 10'h001, 3);
    one_shot(3, 50, 1'b1, 10'h3FF, 1);

    run_block(2, 1000, 1'b0, 4, 10'h000);  // R3 fixed, acq ignored
    run_block(2, 0,    1'b1, 4, 10'h3FF);  // R4 tail dominates, 32 halves
    run_block(3, 40,   1'b1, 3, 10'h155);  // R4 acq dominates, 40 halves
    run_block(1, 7,    1'b1, 3, 10'h2AA);  // R4 boundary, 32 halves
    run_block(1, 8,    1'b1, 3, 10'h100);  // R4 half pad, 34 halves
    run_block(4, 100,  1'b1, 3, 10'h0AA);  // R4 50 halves
    run_block(5, 0,    1'b0, 3, 10'h3C3);  // R3 slower divider

    repeat (20) @(negedge clk);
    chk(eq.size() == 0, "R5", eq.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule